// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block models the command side of a NOR-style parallel flash on a 32-bit memory-mapped bus. The array is treated as two 16-bit devices side by side. A write made while the controller is idle is not data. Its low byte is decoded as a command that selects the next state and the read mode. A write made after a setup command is the second half of a two-step operation: word program, block erase, or block lock/unlock. A status register collects error flags for these operations until software clears it.

The storage is a small parameterised register array split into erase blocks, with one lock bit per block. Reads are registered. Depending on the current read mode, a read returns array data, the status byte, identification words or a query byte. Every access completes in one clock cycle. Byte enables qualify program data. There is no program or erase delay, so the ready flag is always set.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the controller is idle and in array read mode, status is 0x80, every block is unlocked, every array byte reads 0xFF, and `bus_rdata` is 0.
- R2: In the idle state the write address is ignored and only `bus_wdata[7:0]` is decoded. 0x70 selects status mode, 0x90 identification mode, 0x98 query mode and 0xFF array mode. Any undefined byte selects array mode. A 0xD0 byte while idle changes nothing.
- R3: In every mode other than array, a read returns a 16-bit value placed in bits 15:0 and copied into bits 31:16. In status mode that value is {8'h00, status}.
- R4: A 0x50 command while idle sets status to exactly 0x80 and leaves the read mode unchanged.
- R5: 0x40 or 0x10 while idle selects status mode at once. The next write stores the bytes of `bus_wdata` whose `bus_be` bit is set (bit n covers byte n) at the addressed word.
- R6: 0x20 while idle selects status mode. A following 0xD0 sets every byte of the addressed erase block to 0xFF. Any other following byte ORs 0x30 into status. In both cases the mode is status afterwards.
- R7: After 0x60, a following 0x01 locks the addressed block and 0xD0 unlocks it, and both select status mode. Any other following byte ORs 0x30 into status and leaves the mode unchanged.
- R8: A program or erase confirm aimed at a locked block leaves the array unchanged and ORs 0x12 into status.
- R9: Status error bits (0x02, 0x10, 0x20) accumulate and are cleared only by 0x50.
- R10: In identification mode the word index is the word offset inside the erase block. Index 0 returns 0x0000, index 1 returns 0xFFFF, index 2 returns the lock bit of the addressed block, and every other index returns 0.
- R11: In query mode the byte index is the address divided by 4, and each byte is returned as {8'h00, byte}. The table is: 0x10–0x12 = 0x51 0x52 0x59; 0x13 = 0x01; 0x15 = 0x31; 0x27 = log2 of the bytes per device; 0x28 = 0x05; 0x2C = 0x01; 0x2D/0x2E = block count minus one; 0x2F/0x30 = bytes per device per block; 0x31–0x33 = 0x50 0x52 0x49. Every other index returns 0.
- R12: 0xE8 while idle selects status mode and keeps the controller idle, so the next write is decoded as a command.
- R13: `bus_rdata` changes only at a clock edge where `bus_rd` is high. It then holds the value for the mode and address seen at that edge.
- R14: After any write in a setup state (lock, program or erase), the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, data registered at this edge |
| bus_addr | input | ADDR_W | Byte address into the array |
| bus_wdata | input | 32 | Write data; bits 7:0 carry commands |
| bus_be | input | 4 | Byte enables for program data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A wrong state or read mode shows up on the first read after the faulty write. That read returns status, identification or array data when a different kind was expected. A lost or spurious lock bit is seen by reading index 2 in identification mode. It also shows up as an unexpected 0x12 in status on the next program of that block. Status accumulation errors show on the next status read. Array corruption appears as soon as the affected word is read back in array mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCK_SET,
    ST_PROG,
    ST_ERASE_SET
  } fstate_e;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_STATUS,
    RM_IDENT,
    RM_QUERY
  } rmode_e;

  localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS  = 8'h70;
  localparam logic [7:0] OP_READ_ID      = 8'h90;
  localparam logic [7:0] OP_READ_QUERY   = 8'h98;
  localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] OP_PROGRAM      = 8'h40;
  localparam logic [7:0] OP_PROGRAM_ALT  = 8'h10;
  localparam logic [7:0] OP_LOCK_SETUP   = 8'h60;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] OP_BUF_SETUP    = 8'hE8;
  localparam logic [7:0] OP_CONFIRM      = 8'hD0;
  localparam logic [7:0] OP_LOCK         = 8'h01;

  localparam logic [7:0] SR_READY     = 8'h80;
  localparam logic [7:0] SR_PROTECT   = 8'h02;
  localparam logic [7:0] SR_PROG_ERR  = 8'h10;
  localparam logic [7:0] SR_ERASE_ERR = 8'h20;
  localparam logic [7:0] SR_LOCK_FAIL = SR_PROG_ERR | SR_PROTECT;
  localparam logic [7:0] SR_SEQ_FAIL  = SR_ERASE_ERR | SR_PROG_ERR;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            cmd,
  input  logic [BLK_W-1:0]      blk,
  output fstate_e               state,
  output rmode_e                rmode,
  output logic [7:0]            status,
  output logic [NUM_BLOCKS-1:0] locks,
  output logic                  prog_we,
  output logic                  erase_go
);

  logic blk_locked;

  always_comb begin
    blk_locked = locks[blk];
    prog_we    = wr_en && (state == ST_PROG) && !blk_locked;
    erase_go   = wr_en && (state == ST_ERASE_SET) && (cmd == OP_CONFIRM) && !blk_locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rmode  <= RM_ARRAY;
      status <= SR_READY;
      locks  <= '0;
    end else if (wr_en) begin
      case (state)
        ST_IDLE: begin
          case (cmd)
            OP_READ_STATUS:  rmode <= RM_STATUS;
            OP_READ_ID:      rmode <= RM_IDENT;
            OP_READ_QUERY:   rmode <= RM_QUERY;
            OP_CLEAR_STATUS: status <= SR_READY;
            OP_PROGRAM, OP_PROGRAM_ALT: begin
              state <= ST_PROG;
              rmode <= RM_STATUS;
            end
            OP_LOCK_SETUP:   state <= ST_LOCK_SET;
            OP_ERASE_SETUP: begin
              state <= ST_ERASE_SET;
              rmode <= RM_STATUS;
            end
            OP_BUF_SETUP:    rmode <= RM_STATUS;
            OP_CONFIRM:      ;
            default:         rmode <= RM_ARRAY;
          endcase
        end
        ST_LOCK_SET: begin
          if (cmd == OP_LOCK) begin
            locks[blk] <= 1'b1;
            rmode      <= RM_STATUS;
          end else if (cmd == OP_CONFIRM) begin
            locks[blk] <= 1'b0;
            rmode      <= RM_STATUS;
          end else begin
            status <= status | SR_SEQ_FAIL;
          end
          state <= ST_IDLE;
        end
        ST_PROG: begin
          if (blk_locked) status <= status | SR_LOCK_FAIL;
          rmode <= RM_STATUS;
          state <= ST_IDLE;
        end
        default: begin
          if (cmd == OP_CONFIRM) begin
            if (blk_locked) status <= status | SR_LOCK_FAIL;
          end else begin
            status <= status | SR_SEQ_FAIL;
          end
          rmode <= RM_STATUS;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int WORDS       = 64,
  parameter int BLOCK_WORDS = 16,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BLK_W  = $clog2(WORDS / BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [WIDX_W-1:0] widx,
  input  logic [31:0]       wdata,
  input  logic              erase,
  input  logic [BLK_W-1:0]  eblk,
  input  logic [WIDX_W-1:0] ridx,
  output logic [31:0]       rword
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (rst) begin
        mem[w] <= '1;
      end else if (erase && (BLK_W'(w / BLOCK_WORDS) == eblk)) begin
        mem[w] <= '1;
      end else if (we && (WIDX_W'(w) == widx)) begin
        for (int b = 0; b < 4; b++) begin
          if (be[b]) mem[w][b*8 +: 8] <= wdata[b*8 +: 8];
        end
      end
    end
  end

  assign rword = mem[ridx];

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_BYTES = 64,
  localparam int ADDR_W   = $clog2(NUM_BLOCKS * BLOCK_BYTES),
  localparam int BLK_LSB  = $clog2(BLOCK_BYTES),
  localparam int SIZE_LOG = $clog2(NUM_BLOCKS * BLOCK_BYTES / 2),
  localparam int DEV_BLK  = BLOCK_BYTES / 2,
  localparam int NB_M1    = NUM_BLOCKS - 1
) (
  input  rmode_e                rmode,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           arr_word,
  input  logic [7:0]            status,
  input  logic [NUM_BLOCKS-1:0] locks,
  output logic [31:0]           rd_next
);

  logic [BLK_LSB-3:0]        id_idx;
  logic [ADDR_W-BLK_LSB-1:0] id_blk;
  logic [15:0]               q_idx;
  logic [7:0]                q_byte;
  logic [15:0]               val16;

  always_comb begin
    id_idx = addr[BLK_LSB-1:2];
    id_blk = addr[ADDR_W-1:BLK_LSB];
    q_idx  = 16'(addr[ADDR_W-1:2]);
    case (q_idx)
      16'h10:  q_byte = 8'h51;
      16'h11:  q_byte = 8'h52;
      16'h12:  q_byte = 8'h59;
      16'h13:  q_byte = 8'h01;
      16'h15:  q_byte = 8'h31;
      16'h27:  q_byte = 8'(SIZE_LOG);
      16'h28:  q_byte = 8'h05;
      16'h2C:  q_byte = 8'h01;
      16'h2D:  q_byte = 8'(NB_M1);
      16'h2E:  q_byte = 8'(NB_M1 >> 8);
      16'h2F:  q_byte = 8'(DEV_BLK);
      16'h30:  q_byte = 8'(DEV_BLK >> 8);
      16'h31:  q_byte = 8'h50;
      16'h32:  q_byte = 8'h52;
      16'h33:  q_byte = 8'h49;
      default: q_byte = 8'h00;
    endcase
    case (rmode)
      RM_STATUS: val16 = {8'h00, status};
      RM_IDENT: begin
        if (id_idx == 0)      val16 = 16'h0000;
        else if (id_idx == 1) val16 = 16'hFFFF;
        else if (id_idx == 2) val16 = {15'h0, locks[id_blk]};
        else                  val16 = 16'h0000;
      end
      RM_QUERY:  val16 = {8'h00, q_byte};
      default:   val16 = 16'h0000;
    endcase
    rd_next = (rmode == RM_ARRAY) ? arr_word : {val16, val16};
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_BYTES = 64,
  localparam int ADDR_W = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata
);

  localparam int WORDS       = NUM_BLOCKS * BLOCK_BYTES / 4;
  localparam int BLOCK_WORDS = BLOCK_BYTES / 4;
  localparam int BLK_LSB     = $clog2(BLOCK_BYTES);
  localparam int BLK_W       = $clog2(NUM_BLOCKS);

  fstate_e               state_q;
  rmode_e                rmode_q;
  logic [7:0]            status_q;
  logic [NUM_BLOCKS-1:0] locks_q;
  logic                  prog_we;
  logic                  erase_go;
  logic [BLK_W-1:0]      blk_sel;
  logic [31:0]           arr_word;
  logic [31:0]           rd_next;

  assign blk_sel = bus_addr[ADDR_W-1:BLK_LSB];

  flash_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .cmd     (bus_wdata[7:0]),
    .blk     (blk_sel),
    .state   (state_q),
    .rmode   (rmode_q),
    .status  (status_q),
    .locks   (locks_q),
    .prog_we (prog_we),
    .erase_go(erase_go)
  );

  flash_store #(.WORDS(WORDS), .BLOCK_WORDS(BLOCK_WORDS)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (prog_we),
    .be   (bus_be),
    .widx (bus_addr[ADDR_W-1:2]),
    .wdata(bus_wdata),
    .erase(erase_go),
    .eblk (blk_sel),
    .ridx (bus_addr[ADDR_W-1:2]),
    .rword(arr_word)
  );

  flash_rd_mux #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_mux (
    .rmode   (rmode_q),
    .addr    (bus_addr),
    .arr_word(arr_word),
    .status  (status_q),
    .locks   (locks_q),
    .rd_next (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            cmd,
  input logic [31:0]           bus_rdata,
  input fstate_e               state,
  input logic [7:0]            status,
  input logic [NUM_BLOCKS-1:0] locks
);

  logic clr_cmd;
  assign clr_cmd = bus_wr && (state == ST_IDLE) && (cmd == OP_CLEAR_STATUS);

  // R4
  clr_status_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (status == 8'h80));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_cmd |=> ((status & $past(status)) == $past(status)));

  // R14
  setup_done_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && state != ST_IDLE) |=> (state == ST_IDLE));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && state == ST_LOCK_SET) |=> $stable(locks));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind flash_cmd_if flash_cmd_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .cmd      (bus_wdata[7:0]),
  .bus_rdata(bus_rdata),
  .state    (state_q),
  .status   (status_q),
  .locks    (locks_q)
);

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  flash_cmd_if u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata)
  );

  // entry: [80] read, [79:72] addr, [71:40] wdata, [39:36] be, [35:4] expected, [3:0] req
  function automatic logic [80:0] vw(logic [7:0] a, logic [31:0] d, logic [3:0] be, logic [3:0] r);
    return {1'b0, a, d, be, 32'h0, r};
  endfunction
  function automatic logic [80:0] vr(logic [7:0] a, logic [31:0] e, logic [3:0] r);
    return {1'b1, a, 32'h0, 4'h0, e, r};
  endfunction

  localparam int NV = 72;
  localparam logic [80:0] VEC [NV] = '{
    vr(8'h00, 32'hFFFFFFFF, 1),   // R1 erased array
    vw(8'h00, 32'h70, 4'hF, 2),   // R2
    vr(8'h00, 32'h00800080, 3),   // R3 status mirrored
    vw(8'h44, 32'h40, 4'hF, 5),   // R5 program
    vr(8'h10, 32'h00800080, 5),
    vw(8'h44, 32'h12345678, 4'hF, 5),
    vw(8'h00, 32'hFF, 4'hF, 2),
    vr(8'h44, 32'h12345678, 5),
    vw(8'h48, 32'h10, 4'hF, 5),
    vw(8'h48, 32'hAABBCCDD, 4'h3, 5),
    vw(8'h00, 32'hFF, 4'hF, 2),
    vr(8'h48, 32'hFFFFCCDD, 5),   // R5 byte enables
    vw(8'h40, 32'h60, 4'hF, 7),   // R7 lock block 1
    vw(8'h40, 32'h01, 4'hF, 7),
    vr(8'h00, 32'h00800080, 7),
    vw(8'h00, 32'h90, 4'hF, 10),  // R10
    vr(8'h08, 32'h00000000, 10),
    vr(8'h48, 32'h00010001, 10),
    vr(8'h44, 32'hFFFFFFFF, 10),
    vr(8'h40, 32'h00000000, 10),
    vr(8'h4C, 32'h00000000, 10),
    vw(8'h50, 32'h40, 4'hF, 8),   // R8 program locked
    vw(8'h50, 32'h00000000, 4'hF, 8),
    vw(8'h00, 32'hFF, 4'hF, 2),
    vr(8'h50, 32'hFFFFFFFF, 8),
    vw(8'h00, 32'h70, 4'hF, 2),
    vr(8'h00, 32'h00920092, 8),
    vw(8'h44, 32'h20, 4'hF, 8),   // R8 erase locked
    vw(8'h44, 32'hD0, 4'hF, 8),
    vr(8'h00, 32'h00920092, 8),
    vw(8'h00, 32'hFF, 4'hF, 2),
    vr(8'h44, 32'h12345678, 8),
    vw(8'hC8, 32'h50, 4'hF, 4),   // R4 clear, address ignored
    vw(8'h00, 32'h70, 4'hF, 2),
    vr(8'h00, 32'h00800080, 4),
    vw(8'h40, 32'h60, 4'hF, 7),   // R7 unlock
    vw(8'h40, 32'hD0, 4'hF, 7),
    vw(8'h00, 32'h90, 4'hF, 10),
    vr(8'h48, 32'h00000000, 7),
    vw(8'h00, 32'h20, 4'hF, 6),   // R6 bad confirm
    vw(8'h00, 32'h33, 4'hF, 6),
    vr(8'h00, 32'h00B000B0, 6),
    vw(8'h00, 32'h60, 4'hF, 9),   // R9 accumulate
    vw(8'h00, 32'h77, 4'hF, 9),
    vr(8'h00, 32'h00B000B0, 9),
    vw(8'h80, 32'h60, 4'hF, 9),
    vw(8'h80, 32'h01, 4'hF, 9),
    vw(8'h80, 32'h40, 4'hF, 9),
    vw(8'h80, 32'h00000000, 4'hF, 9),
    vr(8'h00, 32'h00B200B2, 9),
    vw(8'h44, 32'h20, 4'hF, 6),   // R6 erase block 1
    vw(8'h44, 32'hD0, 4'hF, 6),
    vw(8'h00, 32'hFF, 4'hF, 2),
    vr(8'h44, 32'hFFFFFFFF, 6),
    vr(8'h48, 32'hFFFFFFFF, 6),
    vw(8'h00, 32'h98, 4'hF, 11),  // R11 query
    vr(8'h40, 32'h00510051, 11),
    vr(8'h9C, 32'h00070007, 11),
    vr(8'hB4, 32'h00030003, 11),
    vr(8'hBC, 32'h00200020, 11),
    vr(8'hC4, 32'h00500050, 11),
    vr(8'hFC, 32'h00000000, 11),
    vw(8'h00, 32'hD0, 4'hF, 2),   // R2 confirm while idle
    vr(8'h40, 32'h00510051, 2),
    vw(8'h00, 32'hAB, 4'hF, 2),   // R2 unknown command
    vr(8'h80, 32'hFFFFFFFF, 2),
    vw(8'h00, 32'hE8, 4'hF, 12),  // R12
    vr(8'h00, 32'h00B200B2, 12),
    vw(8'h00, 32'hFF, 4'hF, 12),
    vr(8'h00, 32'hFFFFFFFF, 12),
    vw(8'h00, 32'h90, 4'hF, 10),
    vr(8'h88, 32'h00010001, 10)
  };

  task automatic check(int req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic do_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, bus_rdata, 32'h0);  // R1 reset read data

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        do_rd(VEC[i][79:72], d);
        check(int'(VEC[i][3:0]), d, VEC[i][35:4]);
      end else begin
        do_wr(VEC[i][79:72], VEC[i][71:40], VEC[i][39:36]);
      end
    end

    // R13: mode changes without a read leave bus_rdata untouched
    do_wr(8'h00, 32'h70, 4'hF);
    do_rd(8'h00, d);
    check(13, d, 32'h00B200B2);
    do_wr(8'h00, 32'hFF, 4'hF);
    repeat (3) @(negedge clk);
    check(13, bus_rdata, 32'h00B200B2);
    do_rd(8'h00, d);
    check(13, d, 32'hFFFFFFFF);

    // R14: a non-command write after program setup lands as data, next write is a command
    do_wr(8'h04, 32'h40, 4'hF);
    do_wr(8'h04, 32'h00000090, 4'hF);
    do_wr(8'h00, 32'hFF, 4'hF);
    do_rd(8'h04, d);
    check(14, d, 32'h00000090);

    // R1: reset mid-run restores status, locks and array
    do_wr(8'hC0, 32'h60, 4'hF);
    do_wr(8'hC0, 32'h01, 4'hF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, bus_rdata, 32'h0);
    do_rd(8'h04, d);
    check(1, d, 32'hFFFFFFFF);
    do_wr(8'h00, 32'h90, 4'hF);
    do_rd(8'hC8, d);
    check(1, d, 32'h00000000);
    do_wr(8'h00, 32'h70, 4'hF);
    do_rd(8'h00, d);
    check(1, d, 32'h00800080);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule